// File: doc/BRIEF.md
# Page-Mode OTP ROM Program-Verify Sequencer

This block sits on the programmer side of a one-time-programmable ROM with a 16-bit word. It writes a whole image into the part using the page algorithm. The image is split into pages of four words. For each page the sequencer raises the programming supplies and puts the output-enable pin at high voltage, which enters latch mode. It then strobes the four image words into the part's page latch, one strobe per word at consecutive addresses. After that it releases the high voltage, applies one timed program pulse on chip enable, and reads the four words back.

A page that reads back wrong gets another pulse, using the data already latched, up to a bounded number of tries. After that the run ends in failure. A page that reads back correctly moves the sequencer to the next page, and the retry count starts again from zero. After the last page the supplies return to read levels in a safe order, and every address is read once more in read mode. The run ends with done, and pass shows the outcome.

All timing windows are cycle counts derived from a clock-frequency parameter and rounded up to the next cycle. The image source is addressed by the same address the ROM sees, so `imgData` must present the image word at `romAddr` in the same cycle.

Top module: `otp_page_programmer`

## Requirements
- R1: `vppOn` is never high unless `vccBoost` is high. `vppOn` only changes in a cycle where `chipEnN` is high and was high in the cycle before.
- R2: Each page is latched as four words whose address low two bits run 0, 1, 2, 3. Each latch strobe lasts `ceil(1 µs·f)` cycles, with `chipEnN`=0, `oeHighV`=1 and `vppOn`=1. The address and the driven `wrData` (`busDrive`=1) are stable for at least `ceil(2 µs·f)` cycles before the strobe and for `ceil(2 µs·f)` cycles after it. `oeHighV` is raised at least `ceil(2 µs·f)` cycles before the first strobe of a page.
- R3: Every program pulse holds `chipEnN`=0 with `oeHighV`=0, `outEnN`=1 and `vppOn`=1 for exactly `ceil(50 µs·f)` cycles. With the default 4 MHz clock that is 200 cycles, which lies inside 47.5–52.5 µs.
- R4: After each pulse the four words of the page are read with `chipEnN`=1 and `outEnN`=0, one read per word, and compared with `imgData`.
- R5: A failed page verify leads to another pulse on the same page without re-latching. When the MAX_TRIES-th verify of a page fails (10 by default), the run ends with `done`=1 and `pass`=0, and no further pulse or read follows.
- R6: The retry count restarts at zero for each new page, so pages that each need fewer than MAX_TRIES pulses still pass, even when their total exceeds MAX_TRIES.
- R7: After the last page passes, `vppOn` drops, then `vccBoost` drops. Every address from 0 to WORD_COUNT-1 is then read in ascending order with `chipEnN`=0 and `outEnN`=0. Any mismatch gives `pass`=0.
- R8: `done` rises at the end of a run and stays high, with `pass` unchanged, until the next `start`. `pass`=1 only when every page verify and every final read matched.
- R9: After reset `chipEnN`=1, `outEnN`=1, `oeHighV`=0, `vppOn`=0, `vccBoost`=0, `busDrive`=0, `done`=0 and `pass`=0.
- R10: `busDrive` is never high while `outEnN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run from idle or after done |
| imgData | input | DATA_W | Image word at `romAddr` |
| rdData | input | DATA_W | Data read back from the ROM |
| romAddr | output | ADDR_W | Address to ROM and image source |
| wrData | output | DATA_W | Data to the ROM while `busDrive` is high |
| busDrive | output | 1 | Controller drives the ROM data bus |
| chipEnN | output | 1 | Chip enable, 0 = asserted |
| outEnN | output | 1 | Output enable, 0 = asserted (read) |
| oeHighV | output | 1 | 1 = output-enable pin at high voltage |
| vppOn | output | 1 | 1 = programming supply at program level |
| vccBoost | output | 1 | 1 = core supply at program level |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without mismatch |

## Verification
The assertions check the rules that hold in every cycle. These are the supply ordering and the rule that the programming supply only moves with chip enable high, the high-voltage pin only under supply, the exact program-pulse length, the verify strobes, bus contention, the retry bound and the holding of done. Only the bench scenarios can show the outcomes of a whole run. Those outcomes are the number of pulses given to each page when the ROM model needs several, the failure at the tenth verify, the per-page restart of the retry count, the ascending final read, and a word that verifies under program supplies but misreads at read levels.

// File: rtl/otp_pgm_pkg.sv
package otp_pgm_pkg;

  // Four words per page; the address low bits select the latch slot.
  localparam int PAGE_LG = 2;

  typedef enum logic [4:0] {
    S_IDLE, S_SUPPLY, S_OEHV, S_LSETUP, S_LPULSE, S_LHOLD,
    S_OEREL, S_PSETUP, S_PPULSE, S_PHOLD, S_VSETUP, S_VREAD, S_VCHK,
    S_VPPDN, S_VCCDN, S_RSETUP, S_RREAD, S_RCHK, S_PASS, S_FAIL
  } seqState_t;

  typedef struct packed {
    logic tLoad;
    logic addrClr;
    logic addrInc;
    logic wordClr;
    logic retryClr;
    logic retryInc;
    logic missClr;
    logic cmpEn;
    logic drive;
  } dpCtl_t;

  function automatic int nsToCyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/otp_pgm_datapath.sv
module otp_pgm_datapath
  import otp_pgm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int WORD_COUNT = 16,
  parameter int MAX_TRIES  = 10,
  parameter int TIMER_W    = 8,
  parameter int RETRY_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [TIMER_W-1:0] tLen,
  input  logic [DATA_W-1:0]  imgData,
  input  logic [DATA_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  wrData,
  output logic               timerDone,
  output logic               pageEnd,
  output logic               arrayEnd,
  output logic               retryLast,
  output logic               miss,
  output logic [RETRY_W-1:0] retryCnt
);

  logic [TIMER_W-1:0] tCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (ctl.addrClr) begin
      addr <= '0;
    end else if (ctl.wordClr) begin
      addr[PAGE_LG-1:0] <= '0;
    end else if (ctl.addrInc) begin
      addr <= addr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tCnt <= '0;
    end else if (ctl.tLoad) begin
      tCnt <= tLen - TIMER_W'(1);
    end else if (tCnt != '0) begin
      tCnt <= tCnt - TIMER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCnt <= '0;
    end else if (ctl.retryClr) begin
      retryCnt <= '0;
    end else if (ctl.retryInc) begin
      retryCnt <= retryCnt + RETRY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      miss <= 1'b0;
    end else if (ctl.missClr) begin
      miss <= 1'b0;
    end else if (ctl.cmpEn && (rdData != imgData)) begin
      miss <= 1'b1;
    end
  end

  assign timerDone = (tCnt == '0);
  assign pageEnd   = &addr[PAGE_LG-1:0];
  assign arrayEnd  = (addr == ADDR_W'(WORD_COUNT - 1));
  assign retryLast = (retryCnt == RETRY_W'(MAX_TRIES - 1));
  assign wrData    = ctl.drive ? imgData : '0;

endmodule

// File: rtl/otp_pgm_control.sv
module otp_pgm_control
  import otp_pgm_pkg::*;
#(
  parameter int TIMER_W   = 8,
  parameter int SETUP_CYC = 8,
  parameter int HOLD_CYC  = 8,
  parameter int LATCH_CYC = 4,
  parameter int PULSE_CYC = 200,
  parameter int VPPH_CYC  = 4,
  parameter int ACC_CYC   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               timerDone,
  input  logic               pageEnd,
  input  logic               arrayEnd,
  input  logic               retryLast,
  input  logic               miss,
  output dpCtl_t             ctl,
  output logic [TIMER_W-1:0] tLen,
  output logic               busDrive,
  output logic               chipEnN,
  output logic               outEnN,
  output logic               oeHighV,
  output logic               vppOn,
  output logic               vccBoost,
  output logic               done,
  output logic               pass
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      S_IDLE, S_PASS, S_FAIL:
        if (start) begin
          stateNext    = S_SUPPLY;
          ctl.addrClr  = 1'b1;
          ctl.retryClr = 1'b1;
        end
      S_SUPPLY: if (timerDone) stateNext = S_OEHV;
      S_OEHV:   if (timerDone) stateNext = S_LSETUP;
      S_LSETUP: if (timerDone) stateNext = S_LPULSE;
      S_LPULSE: if (timerDone) stateNext = S_LHOLD;
      S_LHOLD:
        if (timerDone) begin
          if (pageEnd) stateNext = S_OEREL;
          else begin
            stateNext   = S_LSETUP;
            ctl.addrInc = 1'b1;
          end
        end
      S_OEREL:  if (timerDone) stateNext = S_PSETUP;
      S_PSETUP: if (timerDone) stateNext = S_PPULSE;
      S_PPULSE: if (timerDone) stateNext = S_PHOLD;
      S_PHOLD:
        if (timerDone) begin
          stateNext   = S_VSETUP;
          ctl.wordClr = 1'b1;
          ctl.missClr = 1'b1;
        end
      S_VSETUP: if (timerDone) stateNext = S_VREAD;
      S_VREAD:
        if (timerDone) begin
          ctl.cmpEn = 1'b1;
          if (pageEnd) stateNext = S_VCHK;
          else begin
            stateNext   = S_VSETUP;
            ctl.addrInc = 1'b1;
          end
        end
      S_VCHK:
        if (miss) begin
          if (retryLast) stateNext = S_FAIL;
          else begin
            stateNext    = S_PSETUP;
            ctl.retryInc = 1'b1;
          end
        end else if (arrayEnd) begin
          stateNext = S_VPPDN;
        end else begin
          stateNext    = S_OEHV;
          ctl.addrInc  = 1'b1;
          ctl.retryClr = 1'b1;
        end
      S_VPPDN: if (timerDone) stateNext = S_VCCDN;
      S_VCCDN:
        if (timerDone) begin
          stateNext   = S_RSETUP;
          ctl.addrClr = 1'b1;
          ctl.missClr = 1'b1;
        end
      S_RSETUP: if (timerDone) stateNext = S_RREAD;
      S_RREAD:
        if (timerDone) begin
          ctl.cmpEn = 1'b1;
          if (arrayEnd) stateNext = S_RCHK;
          else begin
            stateNext   = S_RSETUP;
            ctl.addrInc = 1'b1;
          end
        end
      S_RCHK: stateNext = miss ? S_FAIL : S_PASS;
      default: stateNext = S_IDLE;
    endcase
    ctl.drive = state inside {S_LSETUP, S_LPULSE, S_LHOLD};
    ctl.tLoad = (stateNext != state);
  end

  // Length of the state being entered.
  always_comb begin
    unique case (stateNext)
      S_SUPPLY, S_OEHV, S_LSETUP, S_OEREL, S_PSETUP, S_VSETUP, S_VCCDN, S_RSETUP:
        tLen = TIMER_W'(SETUP_CYC);
      S_LHOLD, S_PHOLD: tLen = TIMER_W'(HOLD_CYC);
      S_LPULSE:         tLen = TIMER_W'(LATCH_CYC);
      S_PPULSE:         tLen = TIMER_W'(PULSE_CYC);
      S_VREAD, S_RREAD: tLen = TIMER_W'(ACC_CYC);
      S_VPPDN:          tLen = TIMER_W'(VPPH_CYC);
      default:          tLen = TIMER_W'(1);
    endcase
  end

  assign vppOn    = !(state inside {S_IDLE, S_VPPDN, S_VCCDN, S_RSETUP, S_RREAD,
                                    S_RCHK, S_PASS, S_FAIL});
  assign vccBoost = vppOn || (state == S_VPPDN);
  assign oeHighV  = state inside {S_OEHV, S_LSETUP, S_LPULSE, S_LHOLD};
  assign chipEnN  = !(state inside {S_LPULSE, S_PPULSE, S_RSETUP, S_RREAD});
  assign outEnN   = !(state inside {S_VREAD, S_RREAD});
  assign busDrive = ctl.drive;
  assign done     = state inside {S_PASS, S_FAIL};
  assign pass     = (state == S_PASS);

endmodule

// File: rtl/otp_page_programmer.sv
module otp_page_programmer
  import otp_pgm_pkg::*;
#(
  parameter int CLK_MHZ     = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int WORD_COUNT  = 16,
  parameter int MAX_TRIES   = 10,
  parameter int PULSE_NS    = 50000,
  parameter int LATCH_NS    = 1000,
  parameter int SETUP_NS    = 2000,
  parameter int HOLD_NS     = 2000,
  parameter int VPP_HOLD_NS = 1000,
  parameter int ACCESS_NS   = 150
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] imgData,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              busDrive,
  output logic              chipEnN,
  output logic              outEnN,
  output logic              oeHighV,
  output logic              vppOn,
  output logic              vccBoost,
  output logic              done,
  output logic              pass
);

  localparam int SETUP_CYC = nsToCyc(SETUP_NS, CLK_MHZ);
  localparam int HOLD_CYC  = nsToCyc(HOLD_NS, CLK_MHZ);
  localparam int LATCH_CYC = nsToCyc(LATCH_NS, CLK_MHZ);
  localparam int PULSE_CYC = nsToCyc(PULSE_NS, CLK_MHZ);
  localparam int VPPH_CYC  = nsToCyc(VPP_HOLD_NS, CLK_MHZ);
  localparam int ACC_CYC   = nsToCyc(ACCESS_NS, CLK_MHZ);
  localparam int TIMER_W   = $clog2(PULSE_CYC + SETUP_CYC + HOLD_CYC + 1);
  localparam int RETRY_W   = $clog2(MAX_TRIES + 1);

  dpCtl_t             ctl;
  logic [TIMER_W-1:0] tLen;
  logic               timerDone, pageEnd, arrayEnd, retryLast, miss;
  logic [RETRY_W-1:0] retryCnt;

  otp_pgm_control #(
    .TIMER_W(TIMER_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .LATCH_CYC(LATCH_CYC), .PULSE_CYC(PULSE_CYC), .VPPH_CYC(VPPH_CYC),
    .ACC_CYC(ACC_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .timerDone(timerDone), .pageEnd(pageEnd), .arrayEnd(arrayEnd),
    .retryLast(retryLast), .miss(miss),
    .ctl(ctl), .tLen(tLen), .busDrive(busDrive),
    .chipEnN(chipEnN), .outEnN(outEnN), .oeHighV(oeHighV),
    .vppOn(vppOn), .vccBoost(vccBoost), .done(done), .pass(pass)
  );

  otp_pgm_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_COUNT(WORD_COUNT),
    .MAX_TRIES(MAX_TRIES), .TIMER_W(TIMER_W), .RETRY_W(RETRY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tLen(tLen),
    .imgData(imgData), .rdData(rdData),
    .addr(romAddr), .wrData(wrData), .timerDone(timerDone),
    .pageEnd(pageEnd), .arrayEnd(arrayEnd), .retryLast(retryLast),
    .miss(miss), .retryCnt(retryCnt)
  );

endmodule

// File: rtl/otp_pgm_seq_checks.sv
module otp_pgm_seq_checks #(
  parameter int PULSE_CYC = 200,
  parameter int MAX_TRIES = 10,
  parameter int RETRY_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               chipEnN,
  input logic               outEnN,
  input logic               oeHighV,
  input logic               vppOn,
  input logic               vccBoost,
  input logic               busDrive,
  input logic               done,
  input logic [RETRY_W-1:0] retryCnt
);

  logic [31:0] lowLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowLen <= '0;
    else if (chipEnN) lowLen <= '0;
    else              lowLen <= lowLen + 32'd1;
  end

  p_vcc_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    vppOn |-> vccBoost);

  p_vpp_ce_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vppOn) |-> (chipEnN && $past(chipEnN)));

  p_hv_under_vpp_r2: assert property (@(posedge clk) disable iff (!rstN)
    oeHighV |-> (vppOn && outEnN));

  p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(chipEnN) && $past(vppOn && !oeHighV)) |-> (lowLen == 32'(PULSE_CYC)));

  p_verify_ce_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!outEnN && vppOn) |-> chipEnN);

  p_retry_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt < RETRY_W'(MAX_TRIES));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  p_no_contention_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outEnN |-> !busDrive);

endmodule

bind otp_page_programmer otp_pgm_seq_checks #(
  .PULSE_CYC(PULSE_CYC), .MAX_TRIES(MAX_TRIES), .RETRY_W(RETRY_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .chipEnN(chipEnN),
  .outEnN(outEnN), .oeHighV(oeHighV), .vppOn(vppOn), .vccBoost(vccBoost),
  .busDrive(busDrive), .done(done), .retryCnt(retryCnt)
);

// File: tb/otp_page_programmer_tb.sv
module otp_page_programmer_tb;

  localparam int CLK_PERIOD = 250;   // 4 MHz
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int WORDS      = 16;
  localparam int PAGES      = WORDS / 4;
  localparam int EXP_PULSE  = 200;   // 50 us at 4 MHz
  localparam int EXP_SETUP  = 8;     // 2 us at 4 MHz

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [DATA_W-1:0] imgData, rdData, wrData;
  logic [ADDR_W-1:0] romAddr;
  logic busDrive, chipEnN, outEnN, oeHighV, vppOn, vccBoost, done, pass;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_page_programmer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .imgData(imgData), .rdData(rdData),
    .romAddr(romAddr), .wrData(wrData), .busDrive(busDrive), .chipEnN(chipEnN),
    .outEnN(outEnN), .oeHighV(oeHighV), .vppOn(vppOn), .vccBoost(vccBoost),
    .done(done), .pass(pass)
  );

  // image source and ROM model
  logic [DATA_W-1:0] img [256];
  logic [DATA_W-1:0] mem [256];
  logic [DATA_W-1:0] pageLatch [4];
  int need [64];
  int pagePulses [64];
  int totalPulses, badWidth, latches, setupErr, verifyReads, verifyCeErr;
  int readCnt, readOrderErr, supplyErr, contention;
  int run, runPage, stableCnt;
  logic [ADDR_W-1:0] prevAddr;
  logic [DATA_W-1:0] prevData;
  logic prevLatch;
  logic flipEn;
  logic [ADDR_W-1:0] flipAddr;

  int checks = 0, fails = 0, cyc = 0;

  assign imgData = img[romAddr];
  assign rdData  = outEnN ? '0 :
                   (mem[romAddr] ^ ((flipEn && !vccBoost && romAddr == flipAddr) ? 16'h0001 : 16'h0000));

  always @(negedge clk) begin
    logic latchNow;
    latchNow = vppOn && oeHighV && !chipEnN;
    // data/address stability before each latch strobe
    if (busDrive && romAddr == prevAddr && wrData == prevData) stableCnt++;
    else stableCnt = 0;
    if (latchNow && !prevLatch) begin
      if (stableCnt < EXP_SETUP) setupErr++;
      pageLatch[romAddr[1:0]] = wrData;
      latches++;
    end
    prevLatch = latchNow;
    prevAddr  = romAddr;
    prevData  = wrData;
    // program pulse
    if (vppOn && !oeHighV && !chipEnN && outEnN) begin
      run++;
      runPage = int'(romAddr) / 4;
    end else if (run > 0) begin
      if (run < 190 || run > 210 || run != EXP_PULSE) badWidth++;
      else begin
        totalPulses++;
        pagePulses[runPage]++;
        if (pagePulses[runPage] >= need[runPage])
          for (int i = 0; i < 4; i++) mem[runPage*4 + i] = pageLatch[i];
      end
      run = 0;
    end
    // reads
    if (!outEnN && vppOn) begin
      verifyReads++;
      if (!chipEnN) verifyCeErr++;
    end
    if (!outEnN && !vppOn) begin
      if (int'(romAddr) != readCnt || chipEnN || vccBoost) readOrderErr++;
      readCnt++;
    end
    if (vppOn && !vccBoost) supplyErr++;
    if (busDrive && !outEnN) contention++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic prepModel();
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    for (int p = 0; p < 64; p++) begin need[p] = 1; pagePulses[p] = 0; end
    totalPulses = 0; badWidth = 0; latches = 0; setupErr = 0;
    verifyReads = 0; verifyCeErr = 0; readCnt = 0; readOrderErr = 0;
    supplyErr = 0; contention = 0; run = 0; stableCnt = 0; flipEn = 1'b0;
  endtask

  task automatic runSeq();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 40000 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(chipEnN && outEnN, "R9 strobes idle", {chipEnN, outEnN}, 3);
    chk(!oeHighV && !vppOn && !vccBoost, "R9 supplies off", {oeHighV, vppOn, vccBoost}, 0);
    chk(!done && !pass && !busDrive, "R9 status low", {done, pass, busDrive}, 0);
  endtask

  task automatic t_clean();
    int good;
    prepModel();
    runSeq();
    chk(done && pass, "R8 clean run passes", {done, pass}, 3);
    chk(totalPulses == PAGES, "R3 one pulse per page", totalPulses, PAGES);
    chk(badWidth == 0, "R3 pulse width", badWidth, 0);
    chk(latches == WORDS, "R2 latch count", latches, WORDS);
    chk(setupErr == 0, "R2 setup before strobe", setupErr, 0);
    good = 0;
    for (int i = 0; i < WORDS; i++) if (mem[i] == img[i]) good++;
    chk(good == WORDS, "R2 words land at own address", good, WORDS);
    chk(verifyReads == WORDS && verifyCeErr == 0, "R4 verify reads", verifyReads, WORDS);
    chk(readCnt == WORDS && readOrderErr == 0, "R7 final read ascending", readCnt, WORDS);
    chk(supplyErr == 0, "R1 supply order", supplyErr, 0);
    chk(contention == 0, "R10 bus contention", contention, 0);
    repeat (20) @(negedge clk);
    chk(done && pass, "R8 done holds", {done, pass}, 3);
  endtask

  task automatic t_retry();
    prepModel();
    need[2] = 3;
    runSeq();
    chk(done && pass, "R5 retried page passes", {done, pass}, 3);
    chk(pagePulses[2] == 3, "R5 pulses on weak page", pagePulses[2], 3);
    chk(totalPulses == PAGES + 2, "R5 total pulses", totalPulses, PAGES + 2);
    chk(latches == WORDS, "R5 no relatch on retry", latches, WORDS);
    chk(verifyReads == WORDS + 8, "R4 verify after every pulse", verifyReads, WORDS + 8);
  endtask

  task automatic t_perpage();
    prepModel();
    need[0] = 6; need[1] = 6;
    runSeq();
    chk(done && pass, "R6 retry count restarts per page", {done, pass}, 3);
    chk(totalPulses == 14, "R6 total pulses", totalPulses, 14);
  endtask

  task automatic t_limit();
    prepModel();
    need[1] = 99;
    runSeq();
    chk(done && !pass, "R5 limit gives fail", {done, pass}, 2);
    chk(pagePulses[1] == 10, "R5 tries on stuck page", pagePulses[1], 10);
    chk(totalPulses == 11 && pagePulses[2] == 0, "R5 nothing after fail", totalPulses, 11);
    chk(readCnt == 0, "R5 no final read", readCnt, 0);
  endtask

  task automatic t_readfail();
    prepModel();
    flipEn = 1'b1; flipAddr = 8'd9;
    runSeq();
    chk(done && !pass, "R7 read-level mismatch fails", {done, pass}, 2);
    chk(readCnt == WORDS && readOrderErr == 0, "R7 all addresses read", readCnt, WORDS);
    chk(totalPulses == PAGES, "R7 pulses", totalPulses, PAGES);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) img[i] = DATA_W'(16'h5A3C ^ (i * 16'h0B17));
    prevLatch = 1'b0; prevAddr = '0; prevData = '0; flipAddr = '0;
    prepModel();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_clean();
    t_retry();
    t_perpage();
    t_limit();
    t_readfail();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule